// File: doc/BRIEF.md
# NAND Device Identification Sequencer

This block brings an attached NAND flash device out of power-up and works out its geometry without software help. It drives a simple bus-cycle port that issues one command, address or data-read cycle at a time, and it watches the device's ready/busy line. It waits for the device to become ready, resets it, and then probes for a self-describing parameter page. When that probe succeeds, the geometry is picked out of the page as it streams past. When the probe fails, the device is reset a second time, a plain identification read is made, and the device code is looked up in a small built-in table.

On success the block raises a done flag and holds the page size, spare size, pages per block, address-cycle count and bus width steady until reset. Any ready timeout, or a device code missing from the table, ends in an error state with the error flag raised. Both end states are final until reset.

State names, in order of use: `ST_PWR_WAIT` (start-up ready poll), `ST_RST_CMD` (reset command), `ST_RST_WAIT` (post-reset ready poll), `ST_ID_CMD` (identify command), `ST_ID_ADDR` (identify address), `ST_ID_READ` (identify bytes), `ST_PP_CMD` (parameter-page command), `ST_PP_READ` (parameter-page stream), `ST_COMMIT` (geometry latch or table miss), `ST_DONE`, `ST_ERR`. Transitions: `ST_PWR_WAIT`→`ST_RST_CMD` on ready, →`ST_ERR` on timeout; `ST_RST_CMD`→`ST_RST_WAIT` on acknowledge; `ST_RST_WAIT`→`ST_ID_CMD` on ready, →`ST_ERR` on timeout; `ST_ID_CMD`→`ST_ID_ADDR`→`ST_ID_READ` on acknowledge; `ST_ID_READ`→`ST_PP_CMD` on a full signature match, →`ST_RST_CMD` (fallback phase) on any mismatch, →`ST_COMMIT` after the second byte in the fallback phase; `ST_PP_CMD`→`ST_PP_READ` on acknowledge; `ST_PP_READ`→`ST_COMMIT` on the last needed byte; `ST_COMMIT`→`ST_DONE`, or →`ST_ERR` on a table miss.

Top module: `nand_ident_seq`

## Requirements
- R1: After reset no bus cycle is requested while `nand_rdy` is low; if `nand_rdy` stays low for 250 × `CLK_PER_MS` cycles in the start-up poll, the block ends with `id_error`=1.
- R2: The first command is FFh (op code 0 = command); after it the block polls `nand_rdy` for at most 100 × `CLK_PER_MS` cycles and goes to `ST_ERR` on expiry. Ready seen in the final cycle of the window wins over the timeout.
- R3: The probe is command 90h, then an address cycle (op code 1) with value 20h, then four read cycles (op code 2). They must return 4Fh, 4Eh, 46h, 49h in that order for the probe to pass.
- R4: On a pass the block issues command ECh and reads exactly bytes 0 to 101 of the parameter page. It captures the feature field (offset 6, 2 bytes), page bytes (offset 80, 4 bytes), spare bytes (offset 84, 2 bytes), pages per block (offset 92, 4 bytes) and address cycles (offset 101, 1 byte), each little-endian. All other bytes are discarded.
- R5: In the probe path, `geo_bus16` equals bit 0 of the feature field.
- R6: On any signature mismatch the block resets the device again (FFh, same 100 ms ready window). It then issues command 90h with address 00h, reads two bytes, and takes the second as the device code.
- R7: Device codes F0, A0, F2, A2, F1, A1, DA give an 8-bit bus, and C0, B0, C2, B2, C1, B1, CA give a 16-bit bus. All of them report 2048 page bytes and the parameter defaults `LEG_SPARE`, `LEG_PPB`, `LEG_ACYC`.
- R8: A device code not in the R7 list ends with `id_error`=1 and `id_done`=0.
- R9: Once `id_done` or `id_error` is set, it stays set until reset, the other flag stays clear, the geometry outputs stay constant and no further bus cycle is requested.
- R10: `bus_req` stays high with `bus_op` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high; read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nand_rdy | input | 1 | Device ready (1) / busy (0) |
| bus_req | output | 1 | Bus cycle requested |
| bus_op | output | 2 | Cycle kind: 0 command, 1 address, 2 read |
| bus_wdata | output | 8 | Command or address byte |
| bus_ack | input | 1 | Cycle complete, one clock wide |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |
| geo_page_bytes | output | 32 | Data bytes per page |
| geo_spare_bytes | output | 16 | Spare bytes per page |
| geo_pages_per_blk | output | 32 | Pages per erase block |
| geo_addr_cycles | output | 8 | Address cycle count byte |
| geo_bus16 | output | 1 | 1 = 16-bit device bus |
| id_done | output | 1 | Identification finished successfully |
| id_error | output | 1 | Identification failed |

## Verification
The ready poll and the timeout expiry can fall in the same cycle: the last cycle of the post-reset window is both the first cycle ready may be seen and the cycle in which the counter expires. The device model in the bench holds ready low for a programmed number of cycles after the reset command is acknowledged. One run makes ready arrive exactly in the final window cycle, which must continue the sequence to a normal finish. A second run makes ready arrive one cycle later, which must end with the error flag and only the single reset command logged.

// File: rtl/nand_id_pkg.sv
package nand_id_pkg;

    typedef enum logic [1:0] {
        BOP_CMD  = 2'd0,
        BOP_ADDR = 2'd1,
        BOP_READ = 2'd2
    } bus_op_e;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_READID  = 8'h90;
    localparam logic [7:0] CMD_PARAM   = 8'hEC;
    localparam logic [7:0] ADDR_PROBE  = 8'h20;
    localparam logic [7:0] ADDR_LEGACY = 8'h00;

    localparam logic [6:0] PP_OFS_FEAT  = 7'd6;
    localparam logic [6:0] PP_OFS_PAGE  = 7'd80;
    localparam logic [6:0] PP_OFS_SPARE = 7'd84;
    localparam logic [6:0] PP_OFS_PPB   = 7'd92;
    localparam logic [6:0] PP_OFS_ACYC  = 7'd101;

    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        unique case (idx)
            2'd0: return 8'h4F;
            2'd1: return 8'h4E;
            2'd2: return 8'h46;
            default: return 8'h49;
        endcase
    endfunction

    typedef struct packed {
        logic [31:0] page;
        logic [15:0] spare;
        logic [31:0] ppb;
        logic [7:0]  acyc;
        logic        bus16;
    } geom_t;

endpackage

// File: rtl/nand_rdy_timer.sv
module nand_rdy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = en && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    a_r2_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < limit));

endmodule

// File: rtl/nand_pp_parser.sv
module nand_pp_parser
    import nand_id_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        vld,
    input  logic [7:0]  din,
    output logic [15:0] feat,
    output logic [31:0] page,
    output logic [15:0] spare,
    output logic [31:0] ppb,
    output logic [7:0]  acyc,
    output logic        last
);
    logic [6:0] ofs;

    assign last = vld && (ofs == PP_OFS_ACYC);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ofs   <= '0;
            feat  <= '0;
            page  <= '0;
            spare <= '0;
            ppb   <= '0;
            acyc  <= '0;
        end else if (vld) begin
            if (ofs != PP_OFS_ACYC) ofs <= ofs + 7'd1;
            case (ofs)
                PP_OFS_FEAT:          feat[7:0]    <= din;
                PP_OFS_FEAT + 7'd1:   feat[15:8]   <= din;
                PP_OFS_PAGE:          page[7:0]    <= din;
                PP_OFS_PAGE + 7'd1:   page[15:8]   <= din;
                PP_OFS_PAGE + 7'd2:   page[23:16]  <= din;
                PP_OFS_PAGE + 7'd3:   page[31:24]  <= din;
                PP_OFS_SPARE:         spare[7:0]   <= din;
                PP_OFS_SPARE + 7'd1:  spare[15:8]  <= din;
                PP_OFS_PPB:           ppb[7:0]     <= din;
                PP_OFS_PPB + 7'd1:    ppb[15:8]    <= din;
                PP_OFS_PPB + 7'd2:    ppb[23:16]   <= din;
                PP_OFS_PPB + 7'd3:    ppb[31:24]   <= din;
                PP_OFS_ACYC:          acyc         <= din;
                default: ;
            endcase
        end
    end

    a_r4_ofs_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ofs <= PP_OFS_ACYC);

endmodule

// File: rtl/nand_legacy_lut.sv
module nand_legacy_lut (
    input  logic [7:0] dev_code,
    output logic       hit,
    output logic       wide
);
    always_comb begin
        hit  = 1'b1;
        wide = 1'b0;
        case (dev_code)
            8'hF0, 8'hA0, 8'hF2, 8'hA2, 8'hF1, 8'hA1, 8'hDA: wide = 1'b0;
            8'hC0, 8'hB0, 8'hC2, 8'hB2, 8'hC1, 8'hB1, 8'hCA: wide = 1'b1;
            default: hit = 1'b0;
        endcase
    end

    a_r7_wide_implies_hit: assert final (!wide || hit);

endmodule

// File: rtl/nand_ident_seq.sv
module nand_ident_seq
    import nand_id_pkg::*;
#(
    parameter int          CLK_PER_MS = 125000,
    parameter logic [15:0] LEG_SPARE  = 16'd64,
    parameter logic [31:0] LEG_PPB    = 32'd64,
    parameter logic [7:0]  LEG_ACYC   = 8'd5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nand_rdy,
    output logic        bus_req,
    output logic [1:0]  bus_op,
    output logic [7:0]  bus_wdata,
    input  logic        bus_ack,
    input  logic [7:0]  bus_rdata,
    output logic [31:0] geo_page_bytes,
    output logic [15:0] geo_spare_bytes,
    output logic [31:0] geo_pages_per_blk,
    output logic [7:0]  geo_addr_cycles,
    output logic        geo_bus16,
    output logic        id_done,
    output logic        id_error
);
    localparam int LIM_PWR = 250 * CLK_PER_MS;
    localparam int LIM_RST = 100 * CLK_PER_MS;
    localparam int CNT_W   = $clog2(LIM_PWR + 1);

    typedef enum logic [3:0] {
        ST_PWR_WAIT, ST_RST_CMD, ST_RST_WAIT, ST_ID_CMD, ST_ID_ADDR,
        ST_ID_READ, ST_PP_CMD, ST_PP_READ, ST_COMMIT, ST_DONE, ST_ERR
    } state_e;

    state_e     state, nxt;
    logic       legacy;
    logic [1:0] idx;
    logic       sig_ok;
    logic [7:0] dev_code;
    geom_t      geo_q;

    logic        tmr_en, tmo;
    logic [CNT_W-1:0] tmr_lim;
    logic [15:0] pp_feat, pp_spare;
    logic [31:0] pp_page, pp_ppb;
    logic [7:0]  pp_acyc;
    logic        pp_last;
    logic        lut_hit, lut_wide;
    logic        sig_match;

    assign tmr_en  = (state == ST_PWR_WAIT) || (state == ST_RST_WAIT);
    assign tmr_lim = (state == ST_PWR_WAIT) ? CNT_W'(LIM_PWR) : CNT_W'(LIM_RST);
    assign sig_match = sig_ok && (bus_rdata == sig_byte(idx));

    nand_rdy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .limit(tmr_lim), .expired(tmo)
    );

    nand_pp_parser u_parser (
        .clk(clk), .rst_n(rst_n),
        .clr(state == ST_PP_CMD),
        .vld((state == ST_PP_READ) && bus_ack),
        .din(bus_rdata),
        .feat(pp_feat), .page(pp_page), .spare(pp_spare),
        .ppb(pp_ppb), .acyc(pp_acyc), .last(pp_last)
    );

    nand_legacy_lut u_lut (.dev_code(dev_code), .hit(lut_hit), .wide(lut_wide));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWR_WAIT: if (nand_rdy) nxt = ST_RST_CMD; else if (tmo) nxt = ST_ERR;
            ST_RST_CMD:  if (bus_ack) nxt = ST_RST_WAIT;
            ST_RST_WAIT: if (nand_rdy) nxt = ST_ID_CMD; else if (tmo) nxt = ST_ERR;
            ST_ID_CMD:   if (bus_ack) nxt = ST_ID_ADDR;
            ST_ID_ADDR:  if (bus_ack) nxt = ST_ID_READ;
            ST_ID_READ: begin
                if (bus_ack) begin
                    if (legacy) begin
                        if (idx == 2'd1) nxt = ST_COMMIT;
                    end else if (idx == 2'd3) begin
                        nxt = sig_match ? ST_PP_CMD : ST_RST_CMD;
                    end
                end
            end
            ST_PP_CMD:   if (bus_ack) nxt = ST_PP_READ;
            ST_PP_READ:  if (pp_last) nxt = ST_COMMIT;
            ST_COMMIT:   nxt = (legacy && !lut_hit) ? ST_ERR : ST_DONE;
            ST_DONE:     nxt = ST_DONE;
            ST_ERR:      nxt = ST_ERR;
            default:     nxt = ST_ERR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PWR_WAIT;
        else        state <= nxt;
    end

    // Sequencing data and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy   <= 1'b0;
            idx      <= '0;
            sig_ok   <= 1'b1;
            dev_code <= '0;
            geo_q    <= '0;
        end else begin
            unique case (state)
                ST_ID_ADDR: if (bus_ack) begin
                    idx    <= '0;
                    sig_ok <= 1'b1;
                end
                ST_ID_READ: if (bus_ack) begin
                    idx    <= idx + 2'd1;
                    sig_ok <= sig_match;
                    if (legacy && idx == 2'd1) dev_code <= bus_rdata;
                    if (!legacy && idx == 2'd3 && !sig_match) legacy <= 1'b1;
                end
                ST_COMMIT: begin
                    if (legacy) begin
                        geo_q <= '{page: 32'd2048, spare: LEG_SPARE, ppb: LEG_PPB,
                                   acyc: LEG_ACYC, bus16: lut_wide};
                    end else begin
                        geo_q <= '{page: pp_page, spare: pp_spare, ppb: pp_ppb,
                                   acyc: pp_acyc, bus16: pp_feat[0]};
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        bus_req   = 1'b1;
        bus_op    = BOP_CMD;
        bus_wdata = 8'h00;
        unique case (state)
            ST_RST_CMD: bus_wdata = CMD_RESET;
            ST_ID_CMD:  bus_wdata = CMD_READID;
            ST_ID_ADDR: begin
                bus_op    = BOP_ADDR;
                bus_wdata = legacy ? ADDR_LEGACY : ADDR_PROBE;
            end
            ST_ID_READ: bus_op = BOP_READ;
            ST_PP_CMD:  bus_wdata = CMD_PARAM;
            ST_PP_READ: bus_op = BOP_READ;
            default:    bus_req = 1'b0;
        endcase
    end

    assign id_done           = (state == ST_DONE);
    assign id_error          = (state == ST_ERR);
    assign geo_page_bytes    = geo_q.page;
    assign geo_spare_bytes   = geo_q.spare;
    assign geo_pages_per_blk = geo_q.ppb;
    assign geo_addr_cycles   = geo_q.acyc;
    assign geo_bus16         = geo_q.bus16;

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_wdata)));
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_done |=> (id_done && $stable(geo_page_bytes) && $stable(geo_pages_per_blk)
                     && $stable(geo_spare_bytes) && $stable(geo_addr_cycles) && $stable(geo_bus16)));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_error |=> id_error);
    a_r9_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (id_done || id_error) |-> !bus_req);
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_done && id_error));
    a_r1_no_req_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWR_WAIT) |-> !bus_req);

endmodule

// File: tb/nand_ident_seq_tb.sv
module nand_ident_seq_tb;
    localparam int CPM     = 4;
    localparam int LIM_PWR = 250 * CPM;
    localparam int LIM_RST = 100 * CPM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nand_rdy = 1'b0;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic [31:0] geo_page_bytes, geo_pages_per_blk;
    logic [15:0] geo_spare_bytes;
    logic [7:0]  geo_addr_cycles;
    logic        geo_bus16, id_done, id_error;

    always #4 clk = ~clk;

    nand_ident_seq #(.CLK_PER_MS(CPM), .LEG_SPARE(16'd64), .LEG_PPB(32'd64), .LEG_ACYC(8'd5)) u_dut (
        .clk(clk), .rst_n(rst_n), .nand_rdy(nand_rdy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .geo_page_bytes(geo_page_bytes), .geo_spare_bytes(geo_spare_bytes),
        .geo_pages_per_blk(geo_pages_per_blk), .geo_addr_cycles(geo_addr_cycles),
        .geo_bus16(geo_bus16), .id_done(id_done), .id_error(id_error)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---- device model settings ----
    logic [31:0] dv_sig;
    logic [7:0]  dv_code;
    int          dv_pwr_delay, dv_rst_delay1, dv_rst_delay2, dv_lat;
    logic [15:0] dv_feat, dv_spare;
    logic [31:0] dv_page, dv_ppb;
    logic [7:0]  dv_acyc;
    // ---- device model observations ----
    logic [31:0] log_cmd;
    logic [15:0] log_addr;
    int          n_pp_reads, n_early_req, n_hold_bad, n_req_after_end, n_ops;

    function automatic logic [7:0] pp_byte(input int i);
        if (i == 6 || i == 7)        return dv_feat[8*(i-6) +: 8];
        if (i >= 80 && i <= 83)      return dv_page[8*(i-80) +: 8];
        if (i == 84 || i == 85)      return dv_spare[8*(i-84) +: 8];
        if (i >= 92 && i <= 95)      return dv_ppb[8*(i-92) +: 8];
        if (i == 101)                return dv_acyc;
        return 8'(i * 3 + 1);
    endfunction

    // Device model: drives ready and the bus acknowledge at falling edges
    initial begin
        int  busy, wcnt, ptr;
        bit  rst_pend, in_pp;
        logic [7:0] last_addr;
        logic [1:0] h_op;
        logic [7:0] h_wd;
        busy = 0; wcnt = 0; ptr = 0; rst_pend = 0; in_pp = 0; last_addr = 0;
        h_op = 0; h_wd = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                busy = dv_pwr_delay; nand_rdy = (busy == 0); bus_ack = 0;
                wcnt = 0; rst_pend = 0; in_pp = 0; ptr = 0;
                continue;
            end
            if (busy > 0) begin
                busy--;
                if (busy == 0) nand_rdy = 1'b1;
            end
            if ((id_done || id_error) && bus_req) n_req_after_end++;
            if (bus_req && n_ops == 0 && !nand_rdy) n_early_req++;
            if (bus_ack) begin
                bus_ack = 1'b0;
                if (rst_pend) begin
                    rst_pend = 0;
                    busy = (log_cmd[15:8] == 8'hFF && log_cmd[7:0] == 8'hFF) ? 0 :
                           ((n_ops > 1) ? dv_rst_delay2 : dv_rst_delay1);
                    nand_rdy = (busy == 0);
                end
            end else if (bus_req) begin
                if (wcnt == 0) begin h_op = bus_op; h_wd = bus_wdata; end
                else if (h_op != bus_op || h_wd != bus_wdata) n_hold_bad++;
                if (wcnt < dv_lat) begin
                    wcnt++;
                end else begin
                    wcnt = 0;
                    bus_ack = 1'b1;
                    n_ops++;
                    unique case (bus_op)
                        2'd0: begin
                            log_cmd = {log_cmd[23:0], bus_wdata};
                            ptr = 0;
                            in_pp = (bus_wdata == 8'hEC);
                            if (bus_wdata == 8'hFF) rst_pend = 1;
                        end
                        2'd1: begin
                            log_addr = {log_addr[7:0], bus_wdata};
                            last_addr = bus_wdata;
                        end
                        default: begin
                            if (in_pp) begin
                                bus_rdata = pp_byte(ptr);
                                n_pp_reads++;
                            end else if (last_addr == 8'h20) begin
                                bus_rdata = (ptr < 4) ? dv_sig[8*(3-ptr) +: 8] : 8'h00;
                            end else begin
                                bus_rdata = (ptr == 0) ? 8'h2C : ((ptr == 1) ? dv_code : 8'h00);
                            end
                            ptr++;
                        end
                    endcase
                end
            end
        end
    end

    // ---- scoreboard ----
    typedef struct {
        bit          is_err;
        logic [31:0] page;
        logic [15:0] spare;
        logic [31:0] ppb;
        logic [7:0]  acyc;
        logic        b16;
        logic [31:0] cmds;
        logic [15:0] addrs;
        int          pp_reads;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    bit   mon_done = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !mon_done && (id_done || id_error) && sb_q.size() > 0) begin
                exp_t e;
                logic [31:0] s_page, s_ppb;
                logic [15:0] s_spare;
                logic [7:0]  s_acyc;
                logic        s_b16;
                e = sb_q.pop_front();
                check(id_error == e.is_err, e.tag, "error flag", 32'(id_error), 32'(e.is_err));
                check(id_done == !e.is_err, e.tag, "done flag", 32'(id_done), 32'(!e.is_err));
                check(log_cmd == e.cmds, e.tag, "command log", log_cmd, e.cmds);
                check(log_addr == e.addrs, e.tag, "address log", 32'(log_addr), 32'(e.addrs));
                if (!e.is_err) begin
                    check(geo_page_bytes == e.page, e.tag, "page bytes", geo_page_bytes, e.page);
                    check(geo_spare_bytes == e.spare, e.tag, "spare bytes", 32'(geo_spare_bytes), 32'(e.spare));
                    check(geo_pages_per_blk == e.ppb, e.tag, "pages per block", geo_pages_per_blk, e.ppb);
                    check(geo_addr_cycles == e.acyc, e.tag, "address cycles", 32'(geo_addr_cycles), 32'(e.acyc));
                    check(geo_bus16 == e.b16, e.tag, "bus16", 32'(geo_bus16), 32'(e.b16));
                    check(n_pp_reads == e.pp_reads, e.tag, "page reads R4", 32'(n_pp_reads), 32'(e.pp_reads));
                end
                s_page = geo_page_bytes; s_ppb = geo_pages_per_blk; s_spare = geo_spare_bytes;
                s_acyc = geo_addr_cycles; s_b16 = geo_bus16;
                repeat (20) @(negedge clk);
                check(id_done == !e.is_err && id_error == e.is_err, "R9", "flags sticky",
                      {30'd0, id_done, id_error}, {30'd0, !e.is_err, e.is_err});
                check(geo_page_bytes == s_page && geo_pages_per_blk == s_ppb &&
                      geo_spare_bytes == s_spare && geo_addr_cycles == s_acyc &&
                      geo_bus16 == s_b16, "R9", "geometry stable", geo_page_bytes, s_page);
                check(n_req_after_end == 0, "R9", "requests after end", 32'(n_req_after_end), 32'd0);
                check(n_hold_bad == 0, "R10", "request held stable", 32'(n_hold_bad), 32'd0);
                check(n_early_req == 0, "R1", "request before ready", 32'(n_early_req), 32'd0);
                mon_done = 1;
            end
        end
    end

    task automatic run_case(input exp_t e, input int max_cycles);
        int waited;
        sb_q.push_back(e);
        log_cmd = 0; log_addr = 0; n_pp_reads = 0; n_early_req = 0;
        n_hold_bad = 0; n_req_after_end = 0; n_ops = 0;
        mon_done = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!bus_req && !id_done && !id_error, "R1", "reset state",
              {29'd0, bus_req, id_done, id_error}, 32'd0);
        rst_n = 1'b1;
        waited = 0;
        while (!mon_done && waited < max_cycles) begin
            @(negedge clk);
            waited++;
        end
        if (!mon_done) begin
            check(1'b0, e.tag, "watchdog expired", 32'(waited), 32'(max_cycles));
            sb_q.delete();
        end
    endtask

    function automatic exp_t mk(input bit err, input logic [31:0] pg, input logic [15:0] sp,
                                input logic [31:0] pb, input logic [7:0] ac, input logic b16,
                                input logic [31:0] cm, input logic [15:0] ad, input int npp,
                                input string tag);
        exp_t e;
        e.is_err = err; e.page = pg; e.spare = sp; e.ppb = pb; e.acyc = ac; e.b16 = b16;
        e.cmds = cm; e.addrs = ad; e.pp_reads = npp; e.tag = tag;
        return e;
    endfunction

    localparam logic [31:0] SIG_OK  = 32'h4F4E4649;
    localparam logic [31:0] CMDS_P  = 32'h00FF90EC;
    localparam logic [31:0] CMDS_L  = 32'hFF90FF90;

    initial begin
        dv_sig = SIG_OK; dv_code = 8'hDA; dv_pwr_delay = 30; dv_rst_delay1 = 10;
        dv_rst_delay2 = 10; dv_lat = 0;
        dv_feat = 16'h0001; dv_page = 32'd4096; dv_spare = 16'd224; dv_ppb = 32'd128; dv_acyc = 8'h23;

        // R3 R4 R5: probe path, 16-bit feature bit, with bus wait states (R10)
        dv_lat = 2;
        run_case(mk(0, 32'd4096, 16'd224, 32'd128, 8'h23, 1'b1, CMDS_P, 16'h0020, 102, "R4"), 5000);

        // R4 R5: multi-byte little-endian fields, feature bit 0 clear
        dv_lat = 0; dv_feat = 16'h0018; dv_page = 32'h0000_2000; dv_spare = 16'h0140;
        dv_ppb = 32'h0001_0040; dv_acyc = 8'h34;
        run_case(mk(0, 32'h2000, 16'h0140, 32'h0001_0040, 8'h34, 1'b0, CMDS_P, 16'h0020, 102, "R5"), 5000);

        // R6 R7: last signature byte wrong, legacy code DA (8-bit)
        dv_sig = 32'h4F4E4658; dv_code = 8'hDA;
        run_case(mk(0, 32'd2048, 16'd64, 32'd64, 8'd5, 1'b0, CMDS_L, 16'h2000, 0, "R6"), 5000);

        // R3 R7: first signature byte wrong, legacy code B1 (16-bit)
        dv_sig = 32'h004E4649; dv_code = 8'hB1; dv_lat = 1;
        run_case(mk(0, 32'd2048, 16'd64, 32'd64, 8'd5, 1'b1, CMDS_L, 16'h2000, 0, "R7"), 5000);

        // R8: unknown legacy code
        dv_lat = 0; dv_code = 8'h55;
        run_case(mk(1, 0, 0, 0, 0, 0, CMDS_L, 16'h2000, 0, "R8"), 5000);

        // R2: ready arrives in the final cycle of the reset window -> proceeds
        dv_sig = SIG_OK; dv_rst_delay1 = LIM_RST - 1;
        dv_feat = 16'h0001; dv_page = 32'd8192; dv_spare = 16'd448; dv_ppb = 32'd256; dv_acyc = 8'h23;
        run_case(mk(0, 32'd8192, 16'd448, 32'd256, 8'h23, 1'b1, CMDS_P, 16'h0020, 102, "R2"), 5000);

        // R2: ready one cycle too late -> error after the single reset
        dv_rst_delay1 = LIM_RST;
        run_case(mk(1, 0, 0, 0, 0, 0, 32'h000000FF, 16'h0000, 0, "R2"), 5000);

        // R2 R6: second reset window timing in the fallback path also bounded
        dv_rst_delay1 = 10; dv_rst_delay2 = LIM_RST; dv_sig = 32'h4F4E4600;
        run_case(mk(1, 0, 0, 0, 0, 0, 32'hFF90FF, 16'h0020, 0, "R6"), 5000);

        // R1: ready never comes at start-up
        dv_rst_delay2 = 10; dv_pwr_delay = 1000000;
        run_case(mk(1, 0, 0, 0, 0, 0, 32'h0, 16'h0, 0, "R1"), LIM_PWR + 200);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule